// File: doc/BRIEF.md
# Bus Machine-Cycle Sequencer

This block produces the external bus timing of an 8-bit processor with a 16-bit address bus, one machine cycle at a time. The core logic asks for a cycle type, an address and, for writes, a data byte. The sequencer then drives the active-high strobes, the address bus and the outgoing data, one clock state after another, and raises `done` on the final clock. The six cycle types are opcode fetch, memory read, memory write, I/O read, I/O write and interrupt acknowledge.

A slow device can stretch a cycle by holding `waitIn` high. The sequencer looks at `waitIn` in one clock of the cycle only. Each wait clock repeats the outputs of that clock. Bytes that come back on `dataIn` are captured into `rdData`: opcodes, read data and interrupt vectors. An opcode fetch ends with two refresh clocks. In those clocks the address bus carries a refresh address built from an 8-bit high byte and an internal 8-bit refresh counter. The low seven bits of that counter advance after every fetch.

Top module: `cpuBusSequencer`

## Requirements
- R1: After a synchronous reset the sequencer is idle. All strobes and `done` are low, and `rdData`, `addrBus` and `dataOut` are zero.
- R2: An opcode fetch (kind 0) lasts 4 clocks. In clocks 1 and 2, `m1`, `mreq` and `rd` are high and the request address is on `addrBus`. In clock 3, `mreq` and `rfsh` are high. In clock 4 only `rfsh` is high. In clocks 3 and 4, `addrBus` = {`refreshHi`, refresh counter}.
- R3: An opcode fetch captures `dataIn` into `rdData` at the end of its final clock 2, so the opcode is in `rdData` from clock 3 onward.
- R4: At the end of each fetch, the low 7 bits of the refresh counter increment with wrap from 7F to 00, and bit 7 is kept. A pulse on `rLoad` loads `rLoadVal` on the next edge and takes priority over the increment.
- R5: A memory read (kind 1) lasts 3 clocks. `mreq` and `rd` are high in clocks 1 and 2, and all strobes are low in clock 3. `dataIn` is captured at the end of clock 3.
- R6: A memory write (kind 2) lasts 3 clocks. `mreq` is high in clocks 1 and 2 and `wr` in clock 2 only. `dataOut` carries the write byte in all 3 clocks and is zero in every cycle that is not a write.
- R7: `waitIn` is sampled only in clock 2 of kinds 0 to 4. Each clock in which it is high there adds one clock that repeats the clock-2 outputs. `waitIn` in any other clock, and in any clock of kind 5, has no effect.
- R8: An I/O read (kind 3) or I/O write (kind 4) lasts 4 clocks and never raises `mreq`. `iorq` together with `rd` (read) or `wr` (write) is high in clocks 2, 3 and 4. An I/O read captures `dataIn` at the end of clock 4, and an I/O write drives the write byte on `dataOut` in all 4 clocks.
- R9: An interrupt acknowledge (kind 5) lasts 5 clocks. `m1` is high in clocks 1 to 4 and `iorq` in clocks 3 and 4. `mreq`, `rd` and `wr` stay low. The vector on `dataIn` is captured at the end of clock 4.
- R10: `done` is high only in the final clock of a cycle. A request is taken only while the sequencer is idle or in its `done` clock, and an accepted request has clock 1 in the very next clock. Requests with kinds 6 and 7, and requests made in any other clock, are ignored, and the address and data of the running cycle stay unchanged.
- R11: `mreq` and `iorq` are never high together, and `wr` is high only in clock 2 of a memory write or in clocks 2 to 4 of an I/O write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request a machine cycle |
| reqKind | input | 3 | Cycle kind, 0 to 5 as listed in the requirements |
| reqAddr | input | 16 | Address of the requested cycle |
| reqWrData | input | 8 | Byte to write for kinds 2 and 4 |
| refreshHi | input | 8 | High byte of the refresh address |
| rLoad | input | 1 | Load the refresh counter |
| rLoadVal | input | 8 | Value for the refresh counter |
| waitIn | input | 1 | Wait request from the bus, active high |
| dataIn | input | 8 | Data bus input |
| m1 | output | 1 | Opcode fetch / acknowledge strobe |
| mreq | output | 1 | Memory request strobe |
| iorq | output | 1 | I/O request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| rfsh | output | 1 | Refresh strobe |
| addrBus | output | 16 | Address bus |
| dataOut | output | 8 | Data bus output |
| rdData | output | 8 | Last captured byte |
| done | output | 1 | Final clock of the cycle |

## Verification
A request is driven half a clock before an edge, so clock 1 is observed half a clock after that edge, and every later clock (and every wait clock) shows one clock after the one before. The bench walks a tick counter of its own beside the design and compares the strobes, `done`, `addrBus` and `dataOut` in every clock of every cycle. A captured byte becomes visible one edge after its capture clock, so `rdData` is compared in the first clock after `done`, whether that clock is idle or clock 1 of a following cycle. The refresh counter is checked through the refresh address of the next fetch.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  // Cycle kinds, encoded as on the request port
  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MEMRD = 3'd1,
    CYC_MEMWR = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4,
    CYC_INTA  = 3'd5
  } cycKind_e;

  localparam int KIND_W = 3;
  localparam int TICK_W = 3;

  // Control to datapath strobes
  typedef struct packed {
    logic load;        // latch request address and write data
    logic selRefresh;  // put the refresh address on the bus
    logic driveData;   // drive the write byte
    logic capture;     // take dataIn into rdData
    logic bumpR;       // advance the refresh counter
  } dpCtl_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
#(
  parameter int TW = TICK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [KIND_W-1:0] reqKind,
  input  logic              waitIn,
  output logic              m1,
  output logic              mreq,
  output logic              iorq,
  output logic              rd,
  output logic              wr,
  output logic              rfsh,
  output logic              done,
  output dpCtl_t            ctl
);

  localparam logic [TW-1:0] T1 = TW'(1);
  localparam logic [TW-1:0] T2 = TW'(2);
  localparam logic [TW-1:0] T3 = TW'(3);
  localparam logic [TW-1:0] T4 = TW'(4);
  localparam logic [TW-1:0] T5 = TW'(5);
  localparam logic [KIND_W-1:0] LAST_KIND = KIND_W'(CYC_INTA);

  logic          active;
  cycKind_e      kind;
  logic [TW-1:0] tick;

  logic lastTick, holdWait, accept;

  function automatic logic [TW-1:0] cycLen(input cycKind_e k);
    case (k)
      CYC_FETCH, CYC_IORD, CYC_IOWR: cycLen = T4;
      CYC_INTA:                      cycLen = T5;
      default:                       cycLen = T3;
    endcase
  endfunction

  always_comb begin
    lastTick = active && (tick == cycLen(kind));
    holdWait = active && (kind != CYC_INTA) && (tick == T2) && waitIn;
    accept   = reqValid && (reqKind <= LAST_KIND) && (!active || lastTick);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      kind   <= CYC_FETCH;
      tick   <= '0;
    end else if (accept) begin
      active <= 1'b1;
      kind   <= cycKind_e'(reqKind);
      tick   <= T1;
    end else if (lastTick) begin
      active <= 1'b0;
    end else if (active && !holdWait) begin
      tick <= tick + T1;
    end
  end

  // Per-clock strobe patterns
  always_comb begin
    m1   = 1'b0;
    mreq = 1'b0;
    iorq = 1'b0;
    rd   = 1'b0;
    wr   = 1'b0;
    rfsh = 1'b0;
    ctl  = '0;
    ctl.load = accept;
    done = lastTick;
    if (active) begin
      case (kind)
        CYC_FETCH: begin
          m1   = (tick <= T2);
          rd   = (tick <= T2);
          mreq = (tick <= T3);
          rfsh = (tick >= T3);
          ctl.selRefresh = (tick >= T3);
          ctl.capture    = (tick == T2) && !waitIn;
          ctl.bumpR      = (tick == T4);
        end
        CYC_MEMRD: begin
          mreq = (tick <= T2);
          rd   = (tick <= T2);
          ctl.capture = (tick == T3);
        end
        CYC_MEMWR: begin
          mreq = (tick <= T2);
          wr   = (tick == T2);
          ctl.driveData = 1'b1;
        end
        CYC_IORD: begin
          iorq = (tick >= T2);
          rd   = (tick >= T2);
          ctl.capture = (tick == T4);
        end
        CYC_IOWR: begin
          iorq = (tick >= T2);
          wr   = (tick >= T2);
          ctl.driveData = 1'b1;
        end
        CYC_INTA: begin
          m1   = (tick <= T4);
          iorq = (tick == T3) || (tick == T4);
          ctl.capture = (tick == T4);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/busSeqData.sv
module busSeqData
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dpCtl_t                   ctl,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWrData,
  input  logic [ADDR_W-DATA_W-1:0] refreshHi,
  input  logic                     rLoad,
  input  logic [DATA_W-1:0]        rLoadVal,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [ADDR_W-1:0]        addrBus,
  output logic [DATA_W-1:0]        dataOut,
  output logic [DATA_W-1:0]        rdData
);

  localparam int CNT_W = DATA_W - 1;

  logic [ADDR_W-1:0] addrLatch;
  logic [DATA_W-1:0] wrLatch;
  logic [DATA_W-1:0] rReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrLatch <= '0;
      wrLatch   <= '0;
      rdData    <= '0;
      rReg      <= '0;
    end else begin
      if (ctl.load) begin
        addrLatch <= reqAddr;
        wrLatch   <= reqWrData;
      end
      if (ctl.capture) rdData <= dataIn;
      if (rLoad) begin
        rReg <= rLoadVal;
      end else if (ctl.bumpR) begin
        rReg <= {rReg[DATA_W-1], rReg[CNT_W-1:0] + CNT_W'(1)};
      end
    end
  end

  always_comb begin
    addrBus = ctl.selRefresh ? {refreshHi, rReg} : addrLatch;
    dataOut = ctl.driveData ? wrLatch : '0;
  end

endmodule

// File: rtl/cpuBusSequencer.sv
module cpuBusSequencer
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  input  logic [KIND_W-1:0]        reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWrData,
  input  logic [ADDR_W-DATA_W-1:0] refreshHi,
  input  logic                     rLoad,
  input  logic [DATA_W-1:0]        rLoadVal,
  input  logic                     waitIn,
  input  logic [DATA_W-1:0]        dataIn,
  output logic                     m1,
  output logic                     mreq,
  output logic                     iorq,
  output logic                     rd,
  output logic                     wr,
  output logic                     rfsh,
  output logic [ADDR_W-1:0]        addrBus,
  output logic [DATA_W-1:0]        dataOut,
  output logic [DATA_W-1:0]        rdData,
  output logic                     done
);

  dpCtl_t ctl;

  busSeqCtrl #(.TW(TICK_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind), .waitIn(waitIn),
    .m1(m1), .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr), .rfsh(rfsh),
    .done(done), .ctl(ctl)
  );

  busSeqData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .ctl(ctl), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .refreshHi(refreshHi), .rLoad(rLoad), .rLoadVal(rLoadVal), .dataIn(dataIn),
    .addrBus(addrBus), .dataOut(dataOut), .rdData(rdData)
  );

endmodule

// File: rtl/busSeqChecker.sv
module busSeqChecker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              m1,
  input logic              mreq,
  input logic              iorq,
  input logic              rd,
  input logic              wr,
  input logic              rfsh,
  input logic              done,
  input logic              waitIn,
  input logic [ADDR_W-1:0] addrBus
);

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(m1 || mreq || iorq || rd || wr || rfsh || done))
    else $error("strobe active right after reset");

  assert_refresh_clean_R2: assert property (@(posedge clk) disable iff (rst)
    rfsh |-> (!m1 && !rd && !wr && !iorq))
    else $error("refresh overlaps another strobe");

  assert_wait_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (mreq && rd && waitIn) |=> (mreq && rd && $stable(addrBus)))
    else $error("read strobes dropped under wait");

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && mreq && !waitIn) |=> !wr)
    else $error("memory write strobe longer than one clock");

  assert_no_bus_clash_R11: assert property (@(posedge clk) disable iff (rst)
    !(mreq && iorq))
    else $error("memory and I/O request together");

  assert_wr_qualified_R11: assert property (@(posedge clk) disable iff (rst)
    wr |-> ((mreq ^ iorq) && !rd && !m1))
    else $error("write strobe without a single request");

  assert_ack_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (m1 && iorq) |-> (!mreq && !rd && !wr))
    else $error("acknowledge with memory or data strobes");

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done held for two clocks");

endmodule

bind cpuBusSequencer busSeqChecker #(.ADDR_W(ADDR_W)) u_busSeqChecker (
  .clk(clk), .rst(rst), .m1(m1), .mreq(mreq), .iorq(iorq), .rd(rd), .wr(wr),
  .rfsh(rfsh), .done(done), .waitIn(waitIn), .addrBus(addrBus)
);

// File: tb/test_cpuBusSequencer.sv
module test_cpuBusSequencer;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = '0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWrData = '0;
  logic [7:0]  refreshHi = 8'h3C;
  logic        rLoad = 1'b0;
  logic [7:0]  rLoadVal = '0;
  logic        waitIn = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        m1, mreq, iorq, rd, wr, rfsh, done;
  logic [15:0] addrBus;
  logic [7:0]  dataOut, rdData;

  cpuBusSequencer i_cpuBusSequencer (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .refreshHi(refreshHi), .rLoad(rLoad), .rLoadVal(rLoadVal),
    .waitIn(waitIn), .dataIn(dataIn), .m1(m1), .mreq(mreq), .iorq(iorq), .rd(rd),
    .wr(wr), .rfsh(rfsh), .addrBus(addrBus), .dataOut(dataOut), .rdData(rdData),
    .done(done)
  );

  int nChk = 0;
  int nBad = 0;
  logic [7:0] rModel = '0;
  logic       pendRd = 1'b0;
  logic [7:0] pendVal = '0;
  string      pendTag = "";

  // {m1, mreq, iorq, rd, wr, rfsh, done} expected per kind and clock
  function automatic logic [6:0] expStrobe(int kind, int t);
    case (kind)
      0: expStrobe = (t <= 2) ? 7'b1101000 : (t == 3) ? 7'b0100010 : 7'b0000011;
      1: expStrobe = (t <= 2) ? 7'b0101000 : 7'b0000001;
      2: expStrobe = (t == 1) ? 7'b0100000 : (t == 2) ? 7'b0100100 : 7'b0000001;
      3: expStrobe = (t == 1) ? 7'b0000000 : (t < 4) ? 7'b0011000 : 7'b0011001;
      4: expStrobe = (t == 1) ? 7'b0000000 : (t < 4) ? 7'b0010100 : 7'b0010101;
      default: expStrobe = (t <= 2) ? 7'b1000000 : (t <= 4) ? 7'b1010000 : 7'b0000001;
    endcase
  endfunction

  function automatic int cycLen(int kind);
    cycLen = (kind == 1 || kind == 2) ? 3 : (kind == 5) ? 5 : 4;
  endfunction

  function automatic string kindTag(int kind);
    case (kind)
      0: kindTag = "R2";
      1: kindTag = "R5";
      2: kindTag = "R6/R11";
      3: kindTag = "R8";
      4: kindTag = "R8/R11";
      default: kindTag = "R9";
    endcase
  endfunction

  function automatic logic [6:0] strobes();
    strobes = {m1, mreq, iorq, rd, wr, rfsh, done};
  endfunction

  task automatic checkVec(string tag, logic [30:0] act, logic [30:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: strobes/addr/data got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkPending();
    if (pendRd) begin
      nChk++;
      if (rdData !== pendVal) begin
        nBad++;
        $display("FAIL %s: rdData got %h expected %h", pendTag, rdData, pendVal);
      end
      pendRd = 1'b0;
    end
  endtask

  task automatic idleClock(string tag);
    reqValid = 1'b0;
    @(negedge clk);
    checkPending();
    checkVec(tag, {strobes(), 24'h0}, 31'h0);
  endtask

  task automatic runCycle(int kind, logic [15:0] addr, logic [7:0] wd,
                          logic [7:0] opnd, int waits, bit garbage);
    int t = 1;
    int w = waits;
    int len = cycLen(kind);
    string tag;
    logic [15:0] ea;
    logic [7:0]  ed;
    reqValid  = 1'b1;
    reqKind   = 3'(kind);
    reqAddr   = addr;
    reqWrData = wd;
    @(negedge clk);
    checkPending();
    dataIn = opnd;
    forever begin
      if (garbage && t != len) begin
        reqValid  = 1'b1;
        reqKind   = 3'($urandom % 8);
        reqAddr   = 16'($urandom);
        reqWrData = 8'($urandom);
      end else begin
        reqValid = 1'b0;
      end
      ea  = (kind == 0 && t >= 3) ? {refreshHi, rModel} : addr;
      ed  = (kind == 2 || kind == 4) ? wd : 8'h00;
      tag = kindTag(kind);
      if (kind == 0 && t >= 3) tag = "R4";
      if (t == 2 && w != waits) tag = "R7";
      if (garbage) tag = {tag, "/R10"};
      checkVec(tag, {strobes(), addrBus, dataOut}, {expStrobe(kind, t), ea, ed});
      if (t == len) begin
        waitIn = 1'($urandom);
        break;
      end
      if (t == 2 && kind != 5) begin
        if (w > 0) begin
          waitIn = 1'b1;
          w--;
        end else begin
          waitIn = 1'b0;
          t++;
        end
      end else begin
        waitIn = 1'($urandom);
        t++;
      end
      @(negedge clk);
    end
    if (kind == 0 || kind == 1 || kind == 3 || kind == 5) begin
      pendRd  = 1'b1;
      pendVal = opnd;
      pendTag = (kind == 0) ? "R3" : kindTag(kind);
    end
    if (kind == 0) rModel = {rModel[7], rModel[6:0] + 7'd1};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL R10: watchdog expired, got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checkVec("R1", {strobes(), addrBus, dataOut}, 31'h0);
    nChk++;
    if (rdData !== 8'h00) begin
      nBad++;
      $display("FAIL R1: rdData got %h expected 00", rdData);
    end
    idleClock("R1");

    // Directed: each kind, no waits
    runCycle(0, 16'h1234, 8'h00, 8'hA5, 0, 0); idleClock("R10");
    runCycle(1, 16'h8001, 8'h00, 8'h5A, 0, 0); idleClock("R10");
    runCycle(2, 16'h4002, 8'hC3, 8'h00, 0, 0); idleClock("R10");
    runCycle(3, 16'h00FE, 8'h00, 8'h77, 0, 0); idleClock("R10");
    runCycle(4, 16'h00FF, 8'h99, 8'h00, 0, 0); idleClock("R10");
    runCycle(5, 16'h0038, 8'h00, 8'hE7, 0, 0); idleClock("R10");

    // Waits in clock 2 for each waitable kind (R7)
    runCycle(0, 16'h2000, 8'h00, 8'h11, 3, 0); idleClock("R7");
    runCycle(1, 16'h2001, 8'h00, 8'h22, 2, 0); idleClock("R7");
    runCycle(2, 16'h2002, 8'h33, 8'h00, 1, 0); idleClock("R7");
    runCycle(3, 16'h2003, 8'h00, 8'h44, 2, 0); idleClock("R7");
    runCycle(4, 16'h2004, 8'h55, 8'h00, 1, 0); idleClock("R7");

    // Refresh counter load and wrap (R4)
    rLoad = 1'b1; rLoadVal = 8'hFE; reqValid = 1'b0;
    @(negedge clk);
    checkPending();
    rLoad = 1'b0; rModel = 8'hFE;
    runCycle(0, 16'h3000, 8'h00, 8'h01, 0, 0);
    runCycle(0, 16'h3001, 8'h00, 8'h02, 0, 0);
    runCycle(0, 16'h3002, 8'h00, 8'h03, 0, 0);
    idleClock("R4");
    rLoad = 1'b1; rLoadVal = 8'h7F;
    @(negedge clk);
    rLoad = 1'b0; rModel = 8'h7F;
    refreshHi = 8'hC5;
    runCycle(0, 16'h3003, 8'h00, 8'h04, 0, 0);
    runCycle(0, 16'h3004, 8'h00, 8'h05, 0, 0);
    idleClock("R4");

    // Unknown kinds ignored (R10)
    reqValid = 1'b1; reqKind = 3'd6;
    @(negedge clk);
    reqKind = 3'd7;
    checkVec("R10", {strobes(), 24'h0}, 31'h0);
    @(negedge clk);
    reqValid = 1'b0;
    checkVec("R10", {strobes(), 24'h0}, 31'h0);

    // Back-to-back and requests during a busy cycle (R10)
    runCycle(1, 16'h5000, 8'h00, 8'hAB, 0, 1);
    runCycle(2, 16'h5001, 8'hCD, 8'h00, 1, 1);
    runCycle(5, 16'h0066, 8'h00, 8'hEF, 0, 1);
    runCycle(0, 16'h5002, 8'h00, 8'h12, 0, 0);
    idleClock("R10");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      runCycle(int'($urandom % 6), 16'($urandom), 8'($urandom), 8'($urandom),
               int'($urandom % 3), 1'($urandom));
      if ($urandom % 3 == 0) idleClock("R10");
    end
    idleClock("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule